// File: doc/BRIEF.md
# Parallel Channel Injection Checker

This block runs a self-test over every channel of a front-end board at the same time. When it receives a start command it captures a programmed pulse count and a strobe spacing. It then clears one event counter per channel and issues that many one-clock injection strobes toward the pulse source. While the strobes go out, each channel counter records the hits returned on that channel's line.

After the last strobe the block waits a fixed settle time so that late responses can still arrive. It then compares every counter with the programmed count. The result is a per-channel failure mask and a single pass flag for the whole board, both presented together with a one-cycle done pulse.

The channel count, the counter width, the spacing field width and the settle time are parameters. The defaults are sixteen channels, 24-bit counters and a 16-cycle settle time.

Top module: `chan_inject_checker`

## Requirements
- R1: After reset, `inject`, `done`, `pass` and `fail_mask` are all low.
- R2: A start accepted while idle produces exactly `pulse_count` injection strobes. Each strobe is high for exactly one clock.
- R3: Consecutive strobes start exactly max(`gap`, 4) clocks apart, so a `gap` value below 4 behaves as 4.
- R4: The channel counters are cleared in the first cycle after start is accepted. If a hit arrives in that same cycle, the clear wins and the hit is not counted.
- R5: A hit is counted only from the first strobe cycle up to the end of the settle interval (for a zero count, only during the settle interval). Each counter stops at all ones instead of wrapping.
- R6: The `done` pulse lasts one clock. It is seen exactly SETTLE_CYC+2 clocks after the cycle of the last strobe.
- R7: Bit i of `fail_mask` is 1 exactly when channel i's count differs from the captured pulse count.
- R8: `pass` is 1 exactly when `fail_mask` is all zeros. Both outputs change only in the cycle where `done` is high, and they hold their values until the next done.
- R9: While a run is in progress, `start` is ignored and changes on `pulse_count` or `gap` have no effect. The values captured at start remain in use.
- R10: A `pulse_count` of zero produces no strobes. The run passes when no channel records a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (accepted when idle) |
| pulse_count | input | CW | Number of strobes and expected count per channel |
| gap | input | GW | Clocks between strobe starts (minimum 4 applied) |
| hit | input | NCH | Per-channel response lines |
| inject | output | 1 | One-clock injection strobe |
| done | output | 1 | One-clock end-of-run pulse |
| pass | output | 1 | All channels matched the expected count |
| fail_mask | output | NCH | Bit i set when channel i mismatched |

## Verification
The counter clear and an incoming hit can land in the same cycle.

The bench provokes this by holding every hit line high from before the start command through the clear cycle. It drops the hit lines just before the first strobe and then lets each channel answer each strobe once. The run is judged correct only if it passes with an all-zero mask, which shows that the clear took precedence.

A second overlap is a response to the last strobe that arrives inside the settle window. Doubled responses are used so that the extra hit falls into the gap or settle cycles, and the bench checks that the hit is still counted.

// File: rtl/inj_chk_pkg.sv
package inj_chk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_PULSE  = 3'd2,
    ST_GAP    = 3'd3,
    ST_SETTLE = 3'd4,
    ST_CHECK  = 3'd5
  } run_state_e;

  localparam int unsigned MIN_SPACING = 4;

endpackage

// File: rtl/inj_sequencer.sv
module inj_sequencer
  import inj_chk_pkg::*;
#(
  parameter int unsigned CW         = 24,
  parameter int unsigned GW         = 8,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] pulse_count_i,
  input  logic [GW-1:0] gap_i,
  output logic          clear_o,
  output logic          count_en_o,
  output logic          inject_o,
  output logic          eval_o,
  output logic [CW-1:0] target_o
);

  localparam int unsigned SW = $clog2(SETTLE_CYC + 1) + 1;
  localparam int unsigned TW = (GW > SW) ? GW : SW;
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);

  run_state_e    st_q, st_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic [CW-1:0] sent_q, sent_n;
  logic [CW-1:0] tgt_q, tgt_n;
  logic [GW-1:0] gap_q, gap_n;
  logic [GW-1:0] gap_eff;
  logic [CW-1:0] sent_inc;

  always_comb begin
    gap_eff  = (gap_q < GW'(MIN_SPACING)) ? GW'(MIN_SPACING) : gap_q;
    sent_inc = sent_q + 1'b1;
  end

  always_comb begin
    st_n   = st_q;
    tmr_n  = tmr_q;
    sent_n = sent_q;
    tgt_n  = tgt_q;
    gap_n  = gap_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          tgt_n = pulse_count_i;
          gap_n = gap_i;
          st_n  = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        sent_n = '0;
        if (tgt_q == '0) begin
          st_n  = ST_SETTLE;
          tmr_n = SETTLE_LOAD;
        end else begin
          st_n = ST_PULSE;
        end
      end
      ST_PULSE: begin
        sent_n = sent_inc;
        if (sent_inc == tgt_q) begin
          st_n  = ST_SETTLE;
          tmr_n = SETTLE_LOAD;
        end else begin
          st_n  = ST_GAP;
          tmr_n = TW'(gap_eff) - TW'(2);
        end
      end
      ST_GAP: begin
        if (tmr_q == '0) st_n = ST_PULSE;
        else             tmr_n = tmr_q - 1'b1;
      end
      ST_SETTLE: begin
        if (tmr_q == '0) st_n = ST_CHECK;
        else             tmr_n = tmr_q - 1'b1;
      end
      ST_CHECK: st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      sent_q <= '0;
      tgt_q  <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_n;
      tmr_q  <= tmr_n;
      sent_q <= sent_n;
      tgt_q  <= tgt_n;
      gap_q  <= gap_n;
    end
  end

  always_comb begin
    clear_o    = (st_q == ST_CLEAR);
    inject_o   = (st_q == ST_PULSE);
    count_en_o = (st_q == ST_PULSE) || (st_q == ST_GAP) || (st_q == ST_SETTLE);
    eval_o     = (st_q == ST_CHECK);
    target_o   = tgt_q;
  end

endmodule

// File: rtl/chan_scaler.sv
module chan_scaler #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          hit_i,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = clear_i || (en_i && hit_i && (cnt_q != TOP));
    cnt_n  = clear_i ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/result_eval.sv
module result_eval #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [CW-1:0]     target_i,
  input  logic [NCH*CW-1:0] counts_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [NCH-1:0]    fail_mask_o
);

  logic [NCH-1:0] mismatch;
  logic [NCH-1:0] mask_q;
  logic           pass_q;
  logic           done_q;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign mismatch[i] = (counts_i[i*CW +: CW] != target_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= eval_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pass_q <= 1'b0;
    end else if (eval_i) begin
      mask_q <= mismatch;
      pass_q <= ~|mismatch;
    end
  end

  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_mask_o = mask_q;

endmodule

// File: rtl/chan_inject_checker.sv
module chan_inject_checker #(
  parameter int unsigned NCH        = 16,
  parameter int unsigned CW         = 24,
  parameter int unsigned GW         = 8,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  pulse_count,
  input  logic [GW-1:0]  gap,
  input  logic [NCH-1:0] hit,
  output logic           inject,
  output logic           done,
  output logic           pass,
  output logic [NCH-1:0] fail_mask
);

  logic              clr;
  logic              cnt_en;
  logic              eval;
  logic [CW-1:0]     target;
  logic [NCH*CW-1:0] counts;

  inj_sequencer #(
    .CW(CW), .GW(GW), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .pulse_count_i(pulse_count), .gap_i(gap),
    .clear_o(clr), .count_en_o(cnt_en), .inject_o(inject),
    .eval_o(eval), .target_o(target)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_scaler #(.CW(CW)) u_scl (
      .clk(clk), .rst_n(rst_n), .clear_i(clr), .en_i(cnt_en),
      .hit_i(hit[i]), .count_o(counts[i*CW +: CW])
    );
  end

  result_eval #(.NCH(NCH), .CW(CW)) u_eval (
    .clk(clk), .rst_n(rst_n), .eval_i(eval), .target_i(target),
    .counts_i(counts), .done_o(done), .pass_o(pass),
    .fail_mask_o(fail_mask)
  );

endmodule

// File: rtl/chan_inject_checker_chk.sv
module chan_inject_checker_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           inject,
  input logic           done,
  input logic           pass,
  input logic [NCH-1:0] fail_mask
);

  a_r2_strobe_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> !inject);

  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> !inject ##1 !inject ##1 !inject);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_pass_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (fail_mask == '0)));

  a_r8_results_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_mask != $past(fail_mask)) || (pass != $past(pass))) |-> done);

  a_r6_no_strobe_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inject);

endmodule

bind chan_inject_checker chan_inject_checker_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .inject(inject), .done(done),
  .pass(pass), .fail_mask(fail_mask)
);

// File: tb/sim_chan_inject_checker.sv
module sim_chan_inject_checker;

  localparam int NCH = 16;
  localparam int CW  = 24;
  localparam int GW  = 8;
  localparam int SET = 8;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [CW-1:0]  pulse_count;
  logic [GW-1:0]  gap;
  logic [NCH-1:0] hit;
  logic           inject, done, pass;
  logic [NCH-1:0] fail_mask;

  logic           start1;
  logic [1:0]     hit1;
  logic           inject1, done1, pass1;
  logic [1:0]     fail_mask1;

  int checks = 0;
  int fails  = 0;

  chan_inject_checker #(.NCH(NCH), .CW(CW), .GW(GW), .SETTLE_CYC(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_count(pulse_count),
    .gap(gap), .hit(hit), .inject(inject), .done(done), .pass(pass),
    .fail_mask(fail_mask)
  );

  chan_inject_checker #(.NCH(2), .CW(4), .GW(4), .SETTLE_CYC(4)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .pulse_count(4'd15),
    .gap(4'd4), .hit(hit1), .inject(inject1), .done(done1), .pass(pass1),
    .fail_mask(fail_mask1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // stimulus settings for the responder
  logic [NCH-1:0] resp_mask, dbl_mask, stray;
  logic           prev_inj_r, prev_inj1_r;
  int             cyc;
  int             inj_n, last_inj, per_min, per_max, done_cyc, wide_err;
  logic           prev_inj_m, done_seen, done1_seen;

  always @(negedge clk) begin
    hit        = (inject ? resp_mask : '0) | (prev_inj_r ? dbl_mask : '0) | stray;
    prev_inj_r = inject;
    hit1        = (inject1 ? 2'b11 : 2'b00) | (prev_inj1_r ? 2'b01 : 2'b00);
    prev_inj1_r = inject1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (inject) begin
      if (prev_inj_m) wide_err = wide_err + 1;
      if (last_inj >= 0) begin
        if (cyc - last_inj < per_min) per_min = cyc - last_inj;
        if (cyc - last_inj > per_max) per_max = cyc - last_inj;
      end
      last_inj = cyc;
      inj_n    = inj_n + 1;
    end
    prev_inj_m = inject;
    if (done) begin
      done_cyc  = cyc;
      done_seen = 1'b1;
    end
    if (done1) done1_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    inj_n = 0; last_inj = -1; per_min = 1 << 30; per_max = 0;
    done_cyc = -1; wide_err = 0; done_seen = 1'b0;
  endtask

  // one full run: program, start, optionally disturb, wait, judge
  task automatic run_case(input int n, input int g, input logic [NCH-1:0] rmask,
                          input logic [NCH-1:0] dmask, input logic [NCH-1:0] exp_mask,
                          input bit clr_race, input bit repoke, input string name);
    int per_exp;
    int wait_n;
    per_exp = (g < 4) ? 4 : g;
    @(posedge clk); #1;
    resp_mask = rmask; dbl_mask = dmask;
    pulse_count = CW'(n); gap = GW'(g);
    if (clr_race) stray = '1;
    clear_stats();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;        // accepted at this edge
    @(posedge clk); #1 stray = '0;          // clear cycle edge has passed
    if (repoke) begin
      repeat (3) @(posedge clk);
      #1 start = 1'b1; pulse_count = CW'(n + 6); gap = GW'(4);
      @(posedge clk); #1 start = 1'b0;
    end
    wait_n = 0;
    while (!done_seen && wait_n < 20000) begin
      @(posedge clk); #1;
      wait_n++;
    end
    chk(done_seen, "R6", {name, " done seen"}, done_seen, 1);
    chk(inj_n == n, "R2", {name, " strobe count"}, inj_n, n);
    chk(wide_err == 0, "R2", {name, " strobe width"}, wide_err, 0);
    if (n > 1) begin
      chk(per_min == per_exp, "R3", {name, " min spacing"}, per_min, per_exp);
      chk(per_max == per_exp, "R3", {name, " max spacing"}, per_max, per_exp);
    end
    if (n > 0)
      chk(done_cyc - last_inj == SET + 2, "R6", {name, " done latency"},
          done_cyc - last_inj, SET + 2);
    chk(fail_mask == exp_mask, "R7", {name, " fail mask"}, fail_mask, exp_mask);
    chk(pass == (exp_mask == '0), "R8", {name, " pass"}, pass, (exp_mask == '0));
  endtask

  task automatic t_reset();
    chk(inject == 1'b0, "R1", "reset inject", inject, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(pass == 1'b0, "R1", "reset pass", pass, 0);
    chk(fail_mask == '0, "R1", "reset mask", fail_mask, 0);
  endtask

  task automatic t_all_good();
    run_case(5, 6, '1, '0, '0, 0, 0, "all_good");
  endtask

  task automatic t_missing();   // R7: silent channels 3 and 15
    run_case(3, 0, 16'h7FF7, '0, 16'h8008, 0, 0, "missing");
  endtask

  task automatic t_double();    // R5: late extra hit counted, ch7 overcounts
    run_case(4, 4, '1, 16'h0080, 16'h0080, 0, 0, "double");
  endtask

  task automatic t_hold();      // R8: results held after done
    logic [NCH-1:0] m;
    logic p;
    m = fail_mask; p = pass;
    repeat (25) @(posedge clk);
    #1;
    chk(fail_mask == m, "R8", "hold mask", fail_mask, m);
    chk(pass == p, "R8", "hold pass", pass, p);
    chk(inject == 1'b0, "R8", "idle no strobe", inject, 0);
  endtask

  task automatic t_zero();      // R10
    run_case(0, 5, '1, '0, '0, 0, 0, "zero_count");
  endtask

  task automatic t_clear_race(); // R4: clear beats same-cycle hit
    run_case(2, 5, '1, '0, '0, 1, 0, "clear_race");
  endtask

  task automatic t_busy_start(); // R9
    run_case(3, 10, '1, '0, '0, 0, 1, "busy_start");
  endtask

  task automatic t_saturate();   // R5: 4-bit counter, 30 hits stop at 15
    int wait_n;
    done1_seen = 1'b0;
    @(posedge clk); #1 start1 = 1'b1;
    @(posedge clk); #1 start1 = 1'b0;
    wait_n = 0;
    while (!done1_seen && wait_n < 5000) begin
      @(posedge clk); #1;
      wait_n++;
    end
    chk(done1_seen, "R5", "sat done", done1_seen, 1);
    chk(fail_mask1 == 2'b00, "R5", "saturation mask", fail_mask1, 0);
    chk(pass1 == 1'b1, "R5", "saturation pass", pass1, 1);
  endtask

  initial begin
    cyc = 0; prev_inj_m = 1'b0; prev_inj_r = 1'b0; prev_inj1_r = 1'b0;
    done1_seen = 1'b0;
    clear_stats();
    resp_mask = '0; dbl_mask = '0; stray = '0;
    rst_n = 1'b0; start = 1'b0; start1 = 1'b0;
    pulse_count = '0; gap = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_all_good();
    t_missing();
    t_hold();
    t_double();
    t_zero();
    t_clear_race();
    t_busy_start();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule